// File: doc/BRIEF.md
# Configurable Logic Cell with Storage, Polarity and Pin Control

This block is one output cell of a programmable logic array. It receives a single sum-of-products term and a set of static configuration inputs. From these it forms the value that goes to the device pin and the value that returns to the internal routing. The term can pass straight through, or it can go through a level-sensitive latch or an edge-triggered register. The register can act as a D flip-flop or as a T flip-flop. The storage element is timed by one of several global clock lines, and a polarity bit can invert the term before it is used.

In buried mode the pin is released and acts as an input. The storage element then captures the pin level instead of the term, so an asynchronous external signal can be synchronised into the array. The feedback output carries the stored pin value. The array, the term allocation and the routing are outside this block.

The global clock lines are treated as sampled signals inside the system clock domain `clk_i`. A rising edge on the selected line is seen when the line is high on a `clk_i` edge after being low on the previous one, and the storage updates on that `clk_i` edge. The latch is open on every `clk_i` edge at which the selected line is high. A stored result therefore appears at the outputs one `clk_i` cycle after the selected clock is first seen high.

Top module: `pld_macrocell`

## Requirements
- R1: With `cfg_mode_i`=0 (combinatorial), `cfg_buried_i`=0 and `cfg_invert_i`=0, `pad_o` and `fb_o` both equal `sop_i` in the same cycle, without passing through a register.
- R2: With `cfg_invert_i`=1 the term is inverted before any other use: in combinatorial mode `pad_o`=`~sop_i`, and the latch and the register store `~sop_i`.
- R3: With `cfg_mode_i`=2 or 3 (register) and `cfg_toggle_i`=0, the stored value takes the term on a rising edge of the selected clock. It is visible on `pad_o` and `fb_o` after the `clk_i` edge at which the line is first seen high. It holds while the line stays high, stays low, or falls.
- R4: In register mode with `cfg_toggle_i`=1, the stored value inverts on a rising edge of the selected clock when the term is 1, and holds when the term is 0.
- R5: `cfg_clk_sel_i`=k selects `gclk_i[k]`. Edges on any other clock line leave the stored value unchanged.
- R6: With `cfg_mode_i`=1 (latch), the stored value follows the term one `clk_i` cycle late while the selected clock is high. It holds while that clock is low.
- R7: `pad_oe_o` is 1 only when `oe_i`=1 and `cfg_buried_i`=0. Otherwise the pin is released and `pad_oe_o`=0.
- R8: With `cfg_buried_i`=1, the register or latch captures `pad_i` instead of the term, `cfg_toggle_i` is ignored, and `fb_o` shows the stored pin value. In combinatorial mode, `fb_o` equals `pad_i`.
- R9: In latch and register modes, `pad_o` and `fb_o` both carry the stored value.
- R10: While `rst_ni` is low, the stored value is cleared to 0 at once, so `fb_o`=0 in stored modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the global clock lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gclk_i | input | NUM_CLK | Global clock lines |
| cfg_clk_sel_i | input | CLK_SEL_W | Index of the clock line used by the storage element |
| cfg_mode_i | input | 2 | 0 combinatorial, 1 latch, 2 or 3 register |
| cfg_toggle_i | input | 1 | 1 selects T-type register behaviour |
| cfg_invert_i | input | 1 | 1 inverts the term |
| cfg_buried_i | input | 1 | 1 makes the pin an input and stores the pin level |
| sop_i | input | 1 | Sum-of-products term from the array |
| oe_i | input | 1 | Output enable term |
| pad_i | input | 1 | Level seen at the pin |
| pad_o | output | 1 | Value driven to the pin |
| pad_oe_o | output | 1 | Pin driver enable; 0 means high impedance |
| fb_o | output | 1 | Feedback to the internal routing |

## Verification
A wrong stored value shows up on `fb_o` and `pad_o` exactly one `clk_i` cycle after the selected clock is first seen high. The bench samples at that point and at several later cycles with the line held high or low. This catches both a missed capture and a spurious recapture. An error in the clock selection or in the toggle logic appears as a wrong level after a single pulse. Wrong pin-direction decoding shows at once on `pad_oe_o`.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  typedef enum logic [1:0] {
    MC_COMB  = 2'd0,
    MC_LATCH = 2'd1,
    MC_REG   = 2'd2,
    MC_REG2  = 2'd3
  } mc_mode_e;
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int NUM_CLK   = 2,
  parameter int CLK_SEL_W = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CLK-1:0]   gclk_i,
  input  logic [CLK_SEL_W-1:0] sel_i,
  output logic                 level_o,
  output logic                 rise_o
);
  logic [NUM_CLK-1:0] hit;
  logic               prev_q;

  // one-hot decode of the selected line, out-of-range selects nothing
  for (genvar g = 0; g < NUM_CLK; g++) begin : g_sel
    assign hit[g] = gclk_i[g] && (sel_i == CLK_SEL_W'(g));
  end

  assign level_o = |hit;
  assign rise_o  = level_o && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;
  end

  assert_rise_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mc_store.sv
module mc_store
  import pld_mc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  mc_mode_e mode_i,
  input  logic     toggle_i,
  input  logic     rise_i,
  input  logic     level_i,
  input  logic     d_i,
  output logic     q_o
);
  logic is_reg;
  assign is_reg = (mode_i == MC_REG) || (mode_i == MC_REG2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      unique case (mode_i)
        MC_LATCH:       if (level_i) q_o <= d_i;
        MC_REG, MC_REG2: if (rise_i) q_o <= toggle_i ? (q_o ^ d_i) : d_i;
        default:        q_o <= q_o;
      endcase
    end
  end

  assert_reg_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reg && !rise_i) |=> $stable(q_o));
  assert_dreg_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reg && !toggle_i && rise_i) |=> (q_o == $past(d_i)));
  assert_treg_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_reg && toggle_i && rise_i && d_i) |=> (q_o != $past(q_o)));
  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MC_LATCH && !level_i) |=> $stable(q_o));
  assert_latch_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MC_LATCH && level_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/mc_io.sv
module mc_io
  import pld_mc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  mc_mode_e mode_i,
  input  logic     invert_i,
  input  logic     buried_i,
  input  logic     sop_i,
  input  logic     oe_i,
  input  logic     pad_i,
  input  logic     q_i,
  output logic     d_o,
  output logic     pad_o,
  output logic     pad_oe_o,
  output logic     fb_o
);
  logic term;
  logic comb;

  assign term     = sop_i ^ invert_i;
  assign comb     = (mode_i == MC_COMB);
  assign d_o      = buried_i ? pad_i : term;
  assign pad_o    = comb ? term : q_i;
  assign pad_oe_o = oe_i && !buried_i;
  assign fb_o     = comb ? d_o : q_i;

  assert_fb_matches_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!comb) |-> (fb_o == pad_o));
  assert_buried_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buried_i |-> !pad_oe_o);
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int NUM_CLK   = 2,
  localparam int CLK_SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CLK-1:0]   gclk_i,
  input  logic [CLK_SEL_W-1:0] cfg_clk_sel_i,
  input  logic [1:0]           cfg_mode_i,
  input  logic                 cfg_toggle_i,
  input  logic                 cfg_invert_i,
  input  logic                 cfg_buried_i,
  input  logic                 sop_i,
  input  logic                 oe_i,
  input  logic                 pad_i,
  output logic                 pad_o,
  output logic                 pad_oe_o,
  output logic                 fb_o
);
  mc_mode_e mode;
  logic     level, rise, d, q, tgl;

  assign mode = mc_mode_e'(cfg_mode_i);
  // an input register never toggles
  assign tgl  = cfg_toggle_i && !cfg_buried_i;

  mc_clk_sel #(.NUM_CLK(NUM_CLK), .CLK_SEL_W(CLK_SEL_W)) u_clk (
    .clk_i, .rst_ni, .gclk_i, .sel_i(cfg_clk_sel_i),
    .level_o(level), .rise_o(rise)
  );

  mc_store u_store (
    .clk_i, .rst_ni, .mode_i(mode), .toggle_i(tgl),
    .rise_i(rise), .level_i(level), .d_i(d), .q_o(q)
  );

  mc_io u_io (
    .clk_i, .rst_ni, .mode_i(mode), .invert_i(cfg_invert_i),
    .buried_i(cfg_buried_i), .sop_i, .oe_i, .pad_i, .q_i(q),
    .d_o(d), .pad_o, .pad_oe_o, .fb_o
  );

  assert_reset_clear_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (q == 1'b0));
endmodule

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CLK    = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NUM_CLK-1:0] gclk_i = '0;
  logic [0:0] cfg_clk_sel_i = '0;
  logic [1:0] cfg_mode_i = 2'd2;
  logic cfg_toggle_i = 1'b0, cfg_invert_i = 1'b0, cfg_buried_i = 1'b0;
  logic sop_i = 1'b0, oe_i = 1'b1, pad_i = 1'b0;
  logic pad_o, pad_oe_o, fb_o;
  int checks = 0, failures = 0;

  pld_macrocell #(.NUM_CLK(NUM_CLK)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(input int k);
    @(negedge clk_i); gclk_i[k] = 1'b1;
    @(negedge clk_i); gclk_i[k] = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    cfg_mode_i = 2'd2; sop_i = 1'b1; pulse(0);
    check("R3 pre-reset capture", fb_o, 1'b1);
    rst_ni = 1'b0; #1;
    check("R10 fb cleared", fb_o, 1'b0);
    check("R10 pad cleared", pad_o, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1; sop_i = 1'b0;
    @(negedge clk_i);
    check("R10 held after release", fb_o, 1'b0);
  endtask

  task automatic t_comb();
    cfg_mode_i = 2'd0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); sop_i = i[0]; #1;
      check("R1 pad", pad_o, i[0]);
      check("R1 fb", fb_o, i[0]);
    end
  endtask

  task automatic t_polarity();
    cfg_mode_i = 2'd0; cfg_invert_i = 1'b1;
    sop_i = 1'b1; #1; check("R2 comb inv 1", pad_o, 1'b0);
    sop_i = 1'b0; #1; check("R2 comb inv 0", pad_o, 1'b1);
    cfg_mode_i = 2'd2; pulse(0);
    check("R2 reg inverted", fb_o, 1'b1);
    cfg_invert_i = 1'b0; sop_i = 1'b0; pulse(0);
    check("R2 reg true", fb_o, 1'b0);
  endtask

  task automatic t_reg_d();
    cfg_mode_i = 2'd2; sop_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check("R3 no edge hold", fb_o, 1'b0);
    pulse(0);
    check("R3 capture fb", fb_o, 1'b1);
    check("R9 pad equals stored", pad_o, 1'b1);
    gclk_i[0] = 1'b1; sop_i = 1'b0;
    @(negedge clk_i);
    check("R3 capture 0", fb_o, 1'b0);
    sop_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R3 hold while high", fb_o, 1'b0);
    gclk_i[0] = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R3 hold after fall", fb_o, 1'b0);
    cfg_mode_i = 2'd3; pulse(0);
    check("R3 alt encoding", fb_o, 1'b1);
  endtask

  task automatic t_toggle();
    logic exp;
    cfg_mode_i = 2'd2; cfg_toggle_i = 1'b1; exp = fb_o;
    sop_i = 1'b1;
    pulse(0); exp = ~exp; check("R4 flip 1", fb_o, exp);
    pulse(0); exp = ~exp; check("R4 flip 2", fb_o, exp);
    sop_i = 1'b0;
    pulse(0); check("R4 hold on 0", fb_o, exp);
    cfg_toggle_i = 1'b0;
  endtask

  task automatic t_clk_sel();
    cfg_mode_i = 2'd2; cfg_clk_sel_i = 1'b1; sop_i = 1'b0;
    pulse(1); check("R5 sel1 capture 0", fb_o, 1'b0);
    sop_i = 1'b1;
    pulse(0); check("R5 other clock ignored", fb_o, 1'b0);
    pulse(1); check("R5 sel1 capture 1", fb_o, 1'b1);
    cfg_clk_sel_i = 1'b0;
  endtask

  task automatic t_latch();
    cfg_mode_i = 2'd1; sop_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R6 closed hold", fb_o, 1'b1);
    gclk_i[0] = 1'b1;
    @(negedge clk_i); check("R6 open follow 0", fb_o, 1'b0);
    sop_i = 1'b1;
    @(negedge clk_i); check("R6 open follow 1", fb_o, 1'b1);
    check("R9 latch on pad", pad_o, 1'b1);
    gclk_i[0] = 1'b0; sop_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R6 closed after fall", fb_o, 1'b1);
  endtask

  task automatic t_oe();
    oe_i = 1'b0; cfg_buried_i = 1'b0; #1;
    check("R7 oe low", pad_oe_o, 1'b0);
    oe_i = 1'b1; #1;
    check("R7 oe high", pad_oe_o, 1'b1);
    cfg_buried_i = 1'b1; #1;
    check("R7 buried released", pad_oe_o, 1'b0);
    cfg_buried_i = 1'b0;
  endtask

  task automatic t_buried();
    cfg_buried_i = 1'b1; cfg_mode_i = 2'd2; cfg_toggle_i = 1'b1;
    sop_i = 1'b0; pad_i = 1'b1;
    pulse(0); check("R8 reg captures pin", fb_o, 1'b1);
    pulse(0); check("R8 toggle ignored", fb_o, 1'b1);
    pad_i = 1'b0;
    pulse(0); check("R8 reg captures pin 0", fb_o, 1'b0);
    cfg_toggle_i = 1'b0; cfg_mode_i = 2'd1; pad_i = 1'b1; gclk_i[0] = 1'b1;
    @(negedge clk_i); check("R8 latch captures pin", fb_o, 1'b1);
    gclk_i[0] = 1'b0; cfg_mode_i = 2'd0; pad_i = 1'b0; sop_i = 1'b1; #1;
    check("R8 comb fb is pin", fb_o, 1'b0);
    pad_i = 1'b1; #1;
    check("R8 comb fb is pin 1", fb_o, 1'b1);
    cfg_buried_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset state", fb_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_comb();
    t_polarity();
    t_reg_d();
    t_toggle();
    t_clk_sel();
    t_latch();
    t_oe();
    t_buried();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule